// File: doc/BRIEF.md
# Drift-Free Countdown Interval Timer

This block is a programmable countdown timer for a real-time scheduler. A prescaler divides the system clock by a programmable divisor to make timer ticks. Each tick lowers a signed count by one. When the count falls to zero or below, a sticky interrupt flag is raised.

Software programs the next period by adding an interval to the live count instead of overwriting it. The addition and any tick that lands in the same clock cycle are merged into one update. Because of this, no tick is ever lost during service.

The count keeps running below zero while the interrupt waits for service. The negative value records how late the service came, and the next added interval absorbs that lateness. As a result the schedule has no cumulative drift. A plain overwrite command exists only for initialisation.

Top module: `drift_free_timer`

## Requirements
- R1: After reset the count reads 0, the interrupt is low and the prescaler divisor equals the parameter DIV_RESET (default 4).
- R2: With tickEn high, one tick occurs every D enabled clocks (D is the divisor). Each tick lowers the count by exactly 1. While tickEn is low the prescaler phase and the count hold.
- R3: A write with command 0 (load) sets the count to the signed write data. It does not set the interrupt. A tick falling in the same cycle is discarded.
- R4: A write with command 1 (add) sets the count to count + data. If a tick falls in the same cycle, the count becomes count + data - 1.
- R5: A tick without an add that takes the count from above zero to zero or below sets the interrupt.
- R6: The count keeps decreasing through zero into negative two's-complement values. Ticks below zero do not set the interrupt again.
- R7: The interrupt is sticky until irqAck is high. If a set condition and an acknowledge fall in the same cycle, the set wins.
- R8: After an add, the interrupt is set if and only if the resulting count is zero or less. Otherwise it keeps its prior value.
- R9: A write with command 2 loads the divisor from the low DIV_W data bits and restarts the prescaler phase. That cycle produces no tick. A divisor of 0 acts as 1.
- R10: A write with command 3 changes neither the count nor the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write command strobe |
| wrCmd | input | 2 | 0 load, 1 add, 2 divisor, 3 none |
| wrData | input | CNT_W | Signed write data |
| tickEn | input | 1 | Enables the prescaler |
| irqAck | input | 1 | Write-one interrupt acknowledge |
| count | output | CNT_W | Live signed count |
| irq | output | 1 | Sticky timer interrupt |

## Verification
The bench targets the cycle where an add and a tick coincide. A design that drops the tick there loses one count per service and drifts. It also checks the case where a set and an acknowledge collide; a design that lets the acknowledge win would lose an expiry. It drives the count below zero, and a design that saturated at zero would hide how late service came. Finally, it checks that a divisor of zero and a load-with-tick behave as specified. A random phase with a fixed seed mixes every command with ticks and acknowledges against a bench model.

// File: rtl/dft_pkg.sv
package dft_pkg;
  typedef enum logic [1:0] {
    CMD_LOAD = 2'd0,
    CMD_ADD  = 2'd1,
    CMD_DIV  = 2'd2,
    CMD_NONE = 2'd3
  } dft_cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic load;
    logic add;
  } dft_strobe_t;
endpackage

// File: rtl/dft_ctrl.sv
module dft_ctrl
  import dft_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int DIV_RESET = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [1:0]       wrCmd,
  input  logic [DIV_W-1:0] divData,
  input  logic             tickEn,
  output dft_strobe_t      stb
);
  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] prescCnt;
  logic [DIV_W-1:0] effDiv;
  logic             divWr;
  logic             tickNow;

  always_comb begin
    divWr    = wrEn && (wrCmd == CMD_DIV);
    effDiv   = (divReg == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : divReg;
    tickNow  = tickEn && !divWr && (prescCnt >= effDiv - 1'b1);
    stb.tick = tickNow;
    stb.load = wrEn && (wrCmd == CMD_LOAD);
    stb.add  = wrEn && (wrCmd == CMD_ADD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divReg   <= DIV_W'(DIV_RESET);
      prescCnt <= '0;
    end else if (divWr) begin
      divReg   <= divData;
      prescCnt <= '0;
    end else if (tickNow) begin
      prescCnt <= '0;
    end else if (tickEn) begin
      prescCnt <= prescCnt + 1'b1;
    end
  end

  // R2: ticks only come while enabled
  a_r2_tick_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    stb.tick |-> tickEn);
  // R9: the divisor write cycle never ticks
  a_r9_no_tick_on_div: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrCmd == CMD_DIV) |-> !stb.tick);
  a_r10_cmd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.load, stb.add, divWr}));
endmodule

// File: rtl/dft_datapath.sv
module dft_datapath
  import dft_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dft_strobe_t      stb,
  input  logic [CNT_W-1:0] wrData,
  input  logic             irqAck,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  localparam logic signed [CNT_W-1:0] ZERO = '0;

  logic signed [CNT_W-1:0] cntQ;
  logic signed [CNT_W-1:0] cntD;
  logic signed [CNT_W-1:0] addend;
  logic signed [CNT_W-1:0] tickDec;
  logic                    setIrq;
  logic                    irqQ;

  always_comb begin
    addend  = stb.add ? $signed(wrData) : ZERO;
    tickDec = {{(CNT_W-1){1'b0}}, stb.tick};
    if (stb.load) cntD = $signed(wrData);
    else          cntD = cntQ + addend - tickDec;
    setIrq = !stb.load &&
             ((stb.add && cntD <= ZERO) ||
              (stb.tick && !stb.add && cntQ > ZERO && cntD <= ZERO));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntQ <= ZERO;
      irqQ <= 1'b0;
    end else begin
      cntQ <= cntD;
      if (setIrq)      irqQ <= 1'b1;
      else if (irqAck) irqQ <= 1'b0;
    end
  end

  assign count = cntQ;
  assign irq   = irqQ;

  // R2: nothing moves the count without a strobe
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.tick && !stb.add && !stb.load) |=> $stable(count));
  // R4: coincident tick is folded into the add
  a_r4_add_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.add && stb.tick && !stb.load) |=>
      $signed(count) == $signed($past(count)) + $signed($past(wrData)) - 1);
  // R5: crossing from one to zero raises the flag
  a_r5_zero_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.tick && !stb.add && !stb.load && $signed(count) == 1) |=> irq);
  // R7: acknowledge without a set condition clears the flag
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irqAck && !stb.tick && !stb.add) |=> !irq);
  // R3: load never raises the flag
  a_r3_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.load && !irq) |=> !irq);
endmodule

// File: rtl/drift_free_timer.sv
module drift_free_timer
  import dft_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int DIV_W     = 16,
  parameter int DIV_RESET = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [1:0]       wrCmd,
  input  logic [CNT_W-1:0] wrData,
  input  logic             tickEn,
  input  logic             irqAck,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  dft_strobe_t stb;

  dft_ctrl #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrCmd(wrCmd),
    .divData(wrData[DIV_W-1:0]), .tickEn(tickEn), .stb(stb)
  );

  dft_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wrData(wrData),
    .irqAck(irqAck), .count(count), .irq(irq)
  );
endmodule

// File: tb/drift_free_timer_tb.sv
module drift_free_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wrEn;
  logic [1:0]  wrCmd;
  logic [31:0] wrData;
  logic        tickEn;
  logic        irqAck;
  logic [31:0] count;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  int mCount, mPresc, mDiv;
  bit mIrq;

  always #(CLK_PERIOD/2) clk = ~clk;

  drift_free_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrCmd(wrCmd), .wrData(wrData),
    .tickEn(tickEn), .irqAck(irqAck), .count(count), .irq(irq)
  );

  task automatic chk(string tag, int got, int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // one clock: drive at negedge, advance the model, compare after posedge
  task automatic step(bit en, bit [1:0] cmd, int data, bit te, bit ack, string tag);
    bit divWr, tick, add, load, setI;
    int eff, nxt;
    @(negedge clk);
    wrEn = en; wrCmd = cmd; wrData = data; tickEn = te; irqAck = ack;
    divWr = en && cmd == 2'd2;
    load  = en && cmd == 2'd0;
    add   = en && cmd == 2'd1;
    eff   = (mDiv == 0) ? 1 : mDiv;
    tick  = te && !divWr && (mPresc >= eff - 1);
    if (load) nxt = data;
    else      nxt = mCount + (add ? data : 0) - (tick ? 1 : 0);
    setI = !load && ((add && nxt <= 0) || (tick && !add && mCount > 0 && nxt <= 0));
    if (divWr) begin mDiv = data & 32'hFFFF; mPresc = 0; end
    else if (tick) mPresc = 0;
    else if (te) mPresc = mPresc + 1;
    if (setI) mIrq = 1'b1; else if (ack) mIrq = 1'b0;
    mCount = nxt;
    @(posedge clk); #1;
    chk({tag, " count"}, $signed(count), mCount);
    chk({tag, " irq"}, int'(irq), int'(mIrq));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; wrEn = 0; wrCmd = 0; wrData = 0; tickEn = 0; irqAck = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    mCount = 0; mPresc = 0; mDiv = 4; mIrq = 0;
    chk("R1 reset count", $signed(count), 0);
    chk("R1 reset irq", int'(irq), 0);

    // R1/R2: default divisor 4 -> first tick on the 4th enabled clock
    for (int i = 0; i < 3; i++) step(0, 2'd3, 0, 1, 0, "R2 prescale");
    chk("R2 no tick before 4", $signed(count), 0);
    step(0, 2'd3, 0, 1, 0, "R2 prescale");
    chk("R6 below zero", $signed(count), -1);
    chk("R6 no irq from zero", int'(irq), 0);

    // R9: divisor 0 acts as 1, write cycle has no tick
    step(1, 2'd2, 0, 1, 0, "R9 div write");
    chk("R9 no tick on write", $signed(count), -1);
    step(0, 2'd3, 0, 1, 0, "R9 div one");
    chk("R9 tick every clock", $signed(count), -2);

    // R3: load with tick discards the tick
    step(1, 2'd0, 3, 1, 0, "R3 load");
    chk("R3 load value", $signed(count), 3);
    chk("R3 load no irq", int'(irq), 0);

    // R5/R6/R7
    step(0, 2'd3, 0, 1, 0, "R5 tick");
    step(0, 2'd3, 0, 1, 0, "R5 tick");
    step(0, 2'd3, 0, 1, 0, "R5 tick");
    chk("R5 zero count", $signed(count), 0);
    chk("R5 irq set", int'(irq), 1);
    step(0, 2'd3, 0, 1, 0, "R6 tick");
    chk("R6 negative", $signed(count), -1);
    step(0, 2'd3, 0, 0, 1, "R7 ack");
    chk("R7 ack clears", int'(irq), 0);

    // R4/R8
    step(1, 2'd1, 5, 1, 0, "R4 add tick");
    chk("R4 add with tick", $signed(count), 3);
    chk("R8 positive no irq", int'(irq), 0);
    step(1, 2'd1, -10, 0, 0, "R8 add neg");
    chk("R8 add to neg", $signed(count), -7);
    chk("R8 irq on neg", int'(irq), 1);
    step(0, 2'd3, 0, 0, 1, "R7 ack");
    step(1, 2'd1, 2, 0, 0, "R8 add still neg");
    chk("R8 still neg irq", int'(irq), 1);

    // R7: set wins over ack
    step(1, 2'd0, 1, 0, 1, "R7 load ack");
    chk("R7 ack clear before", int'(irq), 0);
    step(0, 2'd3, 0, 1, 1, "R7 set vs ack");
    chk("R7 set wins", int'(irq), 1);

    // R10: command 3 ignored
    step(1, 2'd3, 99, 0, 0, "R10 none");
    chk("R10 count held", $signed(count), 0);
    chk("R10 irq held", int'(irq), 1);
    step(0, 2'd3, 0, 0, 1, "R7 ack");

    // R2: divisor 2 and tickEn gating
    step(1, 2'd2, 2, 0, 0, "R9 div 2");
    step(1, 2'd0, 10, 0, 0, "R3 load 10");
    step(0, 2'd3, 0, 1, 0, "R2 div2");
    chk("R2 first enabled", $signed(count), 10);
    step(0, 2'd3, 0, 1, 0, "R2 div2");
    chk("R2 tick at 2", $signed(count), 9);
    step(0, 2'd3, 0, 1, 0, "R2 div2");
    step(0, 2'd3, 0, 0, 0, "R2 gated");
    chk("R2 gated hold", $signed(count), 9);
    step(0, 2'd3, 0, 1, 0, "R2 div2");
    chk("R2 resumes", $signed(count), 8);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int r;
      bit en;
      bit [1:0] cmd;
      int data;
      r    = $urandom_range(0, 99);
      en   = r < 25;
      cmd  = (r < 5) ? 2'd0 : (r < 20) ? 2'd1 : (r < 23) ? 2'd2 : 2'd3;
      if (cmd == 2'd2) data = $urandom_range(0, 3);
      else             data = $urandom_range(0, 16) - 4;
      step(en, cmd, data, $urandom_range(0, 9) < 8, $urandom_range(0, 9) < 2,
           "R4 R5 R7 R8 random");
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule